// File: doc/BRIEF.md
# Block-Aware Stream Exit Converter

This block sits at the tail of a chain of stream accelerators that several streams share in turn. It takes the valid/ready sample stream from the last accelerator and turns every sample into a posted write into a circular buffer in the memory of the active stream's consumer. Each stream has its own buffer base, buffer size, block length and pointer address in a small context table, along with a write offset that the block keeps from one turn to the next.

The entry scheduler activates one stream at a time. The block then accepts exactly one block of samples, at up to one per clock, and writes them at consecutive offsets that wrap at the buffer size. After the last sample it posts the new write offset to the stream's pointer address, so the consumer can see the fresh data. It then pulses a drain-done signal, which tells the scheduler the chain is empty and a context switch is safe. The block never issues reads. A write is complete in the cycle the interconnect accepts it.

Addresses are in sample units. Offsets, sizes and block lengths are unsigned. A configured size or block length must be at least one.

Top module: `sec_exit_conv`

## Requirements
- R1: During and after reset, with no activation yet, `wr_valid`, `in_ready`, `drain_done` and `busy` are 0.
- R2: While the block is idle, `in_ready` and `wr_valid` stay 0 whatever `in_valid` does.
- R3: An `act_valid` seen at a clock edge while idle starts stream `act_id`. From the next cycle `busy` is 1 and `in_ready` equals `wr_ready`.
- R4: An accepted sample (`in_valid && in_ready`) is presented in the same cycle as an accepted write (`wr_valid && wr_ready`). That write has `wr_data` equal to `in_data` and `wr_addr` equal to the stream's base plus its current write offset. Back-to-back samples are accepted one per cycle.
- R5: The write offset advances by one per accepted sample and returns to 0 after offset size-1, so the address wraps to the base.
- R6: Once the block-length-th sample is accepted, input is refused (`in_ready` = 0). The next write goes to the stream's pointer address, and its data is the updated write offset, zero-extended.
- R7: `drain_done` is 1 for exactly one cycle, the cycle after the pointer write is accepted. `busy` is 0 in that same cycle.
- R8: Each stream keeps its write offset across activations, so a later block of a stream continues where its previous block stopped, whatever other streams ran in between.
- R9: A configuration write (`cfg_we` with `cfg_id`) sets that stream's base, size, block length and pointer address, and resets its write offset to 0.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, no sample is accepted. During the pointer write, `wr_addr` and `wr_data` hold until the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Context write strobe |
| cfg_id | input | IW | Stream whose context is written |
| cfg_base | input | AW | Buffer base address |
| cfg_size | input | AW | Buffer size in samples (>= 1) |
| cfg_blen | input | CW | Samples per block (>= 1) |
| cfg_paddr | input | AW | Address that receives the write offset |
| act_valid | input | 1 | Activate a stream (taken only when idle) |
| act_id | input | IW | Stream to activate |
| busy | output | 1 | A stream is active |
| drain_done | output | 1 | One-cycle end-of-block notification |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle |
| in_data | input | DW | Sample value |
| wr_valid | output | 1 | Posted write present |
| wr_ready | input | 1 | Interconnect accepts the write |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |

## Verification
The assertions assume a sane environment. Configuration writes never target the stream that is active. Size and block length are never zero. `act_id` always names an existing stream. The bench respects all of these: it writes contexts only while the block is idle, uses nonzero sizes and lengths, and activates only configured streams. It also drops `wr_ready` on alternate cycles and keeps `in_valid` high into the pointer-write and idle phases, so the hold and refusal properties are actually exercised.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STREAM = 2'd1,
    PH_PUB    = 2'd2
  } phase_e;
endpackage

// File: rtl/sec_ctx_table.sv
module sec_ctx_table #(
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_id,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_size,
  input  logic [CW-1:0] cfg_blen,
  input  logic [AW-1:0] cfg_paddr,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_id,
  input  logic [AW-1:0] upd_wptr,
  input  logic [IW-1:0] rd_id,
  output logic [AW-1:0] rd_base,
  output logic [AW-1:0] rd_size,
  output logic [CW-1:0] rd_blen,
  output logic [AW-1:0] rd_paddr,
  output logic [AW-1:0] rd_wptr
);
  logic [AW-1:0] base_q  [NS];
  logic [AW-1:0] size_q  [NS];
  logic [CW-1:0] blen_q  [NS];
  logic [AW-1:0] paddr_q [NS];
  logic [AW-1:0] wptr_q  [NS];

  for (genvar g = 0; g < NS; g++) begin : g_ent
    logic          cfg_hit;
    logic          upd_hit;
    logic [AW-1:0] wptr_d;

    always_comb begin
      cfg_hit = cfg_we && (cfg_id == IW'(g));
      upd_hit = upd_en && (upd_id == IW'(g));
      wptr_d  = wptr_q[g];
      if (upd_hit) wptr_d = upd_wptr;
      if (cfg_hit) wptr_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        size_q[g]  <= '0;
        blen_q[g]  <= '0;
        paddr_q[g] <= '0;
      end else if (cfg_hit) begin
        base_q[g]  <= cfg_base;
        size_q[g]  <= cfg_size;
        blen_q[g]  <= cfg_blen;
        paddr_q[g] <= cfg_paddr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wptr_q[g] <= '0;
      else if (cfg_hit || upd_hit) wptr_q[g] <= wptr_d;
    end
  end

  assign rd_base  = base_q[rd_id];
  assign rd_size  = size_q[rd_id];
  assign rd_blen  = blen_q[rd_id];
  assign rd_paddr = paddr_q[rd_id];
  assign rd_wptr  = wptr_q[rd_id];
endmodule

// File: rtl/sec_wrap_ptr.sv
module sec_wrap_ptr #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] ptr_nxt
);
  logic at_end;

  always_comb begin
    at_end  = (ptr == size - AW'(1)) || (ptr >= size);
    ptr_nxt = at_end ? '0 : ptr + AW'(1);
  end
endmodule

// File: rtl/sec_blk_cnt.sv
module sec_blk_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/sec_exit_conv.sv
module sec_exit_conv #(
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_id,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_size,
  input  logic [CW-1:0] cfg_blen,
  input  logic [AW-1:0] cfg_paddr,
  input  logic          act_valid,
  input  logic [IW-1:0] act_id,
  output logic          busy,
  output logic          drain_done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  import sec_pkg::*;

  phase_e        phase_q, phase_d;
  logic [IW-1:0] id_q;
  logic [AW-1:0] base_q, size_q, paddr_q, off_q, off_d;
  logic          done_q, done_d;
  logic          act_fire, take, last, pub_acc;
  logic          pub_phase;
  logic [AW-1:0] rd_base, rd_size, rd_paddr, rd_wptr, off_nxt;
  logic [CW-1:0] rd_blen;

  sec_ctx_table #(.NS(NS), .AW(AW), .CW(CW)) u_tab (
    .clk, .rst_n,
    .cfg_we, .cfg_id, .cfg_base, .cfg_size, .cfg_blen, .cfg_paddr,
    .upd_en(pub_acc), .upd_id(id_q), .upd_wptr(off_q),
    .rd_id(act_id), .rd_base, .rd_size, .rd_blen, .rd_paddr, .rd_wptr
  );

  sec_wrap_ptr #(.AW(AW)) u_wrap (.ptr(off_q), .size(size_q), .ptr_nxt(off_nxt));

  sec_blk_cnt #(.CW(CW)) u_cnt (
    .clk, .rst_n, .load(act_fire), .load_val(rd_blen), .dec(take), .last
  );

  always_comb begin
    pub_phase = (phase_q == PH_PUB);
    act_fire  = (phase_q == PH_IDLE) && act_valid;
    in_ready  = (phase_q == PH_STREAM) && wr_ready;
    take      = in_valid && in_ready;
    pub_acc   = pub_phase && wr_ready;
    wr_valid  = ((phase_q == PH_STREAM) && in_valid) || pub_phase;
    wr_addr   = pub_phase ? paddr_q : base_q + off_q;
    wr_data   = pub_phase ? DW'(off_q) : in_data;
    busy      = (phase_q != PH_IDLE);
    done_d    = pub_acc;
    off_d     = act_fire ? rd_wptr : off_nxt;
    phase_d   = phase_q;
    case (phase_q)
      PH_IDLE:   if (act_valid)    phase_d = PH_STREAM;
      PH_STREAM: if (take && last) phase_d = PH_PUB;
      PH_PUB:    if (wr_ready)     phase_d = PH_IDLE;
      default:                     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      base_q  <= '0;
      size_q  <= '0;
      paddr_q <= '0;
    end else if (act_fire) begin
      id_q    <= act_id;
      base_q  <= rd_base;
      size_q  <= rd_size;
      paddr_q <= rd_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                off_q <= '0;
    else if (act_fire || take) off_q <= off_d;
  end

  assign drain_done = done_q;
endmodule

// File: rtl/sec_exit_conv_chk.sv
module sec_exit_conv_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          drain_done,
  input logic          pub_phase
);
  // R2: nothing is taken or written while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !wr_valid));

  // R4: every accepted sample is forwarded unchanged by an accepted write
  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (wr_valid && wr_ready && wr_data == in_data));

  // R6: input is refused during the pointer write
  a_r6_no_take_in_pub: assert property (@(posedge clk) disable iff (!rst_n)
    pub_phase |-> !in_ready);

  // R7: drain-done is a single-cycle pulse following an accepted pointer write
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !drain_done);
  a_r7_done_after_pub: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> ($past(pub_phase && wr_ready) && !busy));

  // R10: a stalled pointer write holds its address and data
  a_r10_pub_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pub_phase && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  a_r10_stall_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready);
endmodule

bind sec_exit_conv sec_exit_conv_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
  .drain_done(drain_done), .pub_phase(pub_phase)
);

// File: tb/test_sec_exit_conv.sv
`timescale 1ns/1ps
module test_sec_exit_conv;
  localparam int NS = 4, AW = 16, DW = 32, CW = 16, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_id = '0;
  logic [AW-1:0] cfg_base = '0, cfg_size = '0, cfg_paddr = '0;
  logic [CW-1:0] cfg_blen = '0;
  logic act_valid = 1'b0;
  logic [IW-1:0] act_id = '0;
  logic busy, drain_done, in_ready, wr_valid;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0;
  int m_base[NS], m_size[NS], m_blen[NS], m_paddr[NS], m_wp[NS];

  always #2.5 clk = ~clk;

  sec_exit_conv #(.NS(NS), .AW(AW), .DW(DW), .CW(CW)) i_sec_exit_conv (
    .clk, .rst_n, .cfg_we, .cfg_id, .cfg_base, .cfg_size, .cfg_blen, .cfg_paddr,
    .act_valid, .act_id, .busy, .drain_done, .in_valid, .in_ready, .in_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_data
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int id, input int b, input int s, input int l, input int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_id = IW'(id); cfg_base = AW'(b); cfg_size = AW'(s);
    cfg_blen = CW'(l); cfg_paddr = AW'(p);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[id] = b; m_size[id] = s; m_blen[id] = l; m_paddr[id] = p; m_wp[id] = 0;
  endtask

  // One full block of a stream: activation, samples, pointer write, drain-done
  task automatic run_block(input int id, input bit stall, input int seed);
    int got = 0;
    int cyc = 0;
    @(negedge clk);
    act_valid = 1'b1; act_id = IW'(id);
    @(posedge clk);
    @(negedge clk);
    act_valid = 1'b0;
    chk("R3 busy after activation", busy, 1);
    while (got < m_blen[id] && cyc < 200) begin
      in_valid = 1'b1;
      in_data  = 32'(seed * 256 + got);
      wr_ready = stall ? cyc[0] : 1'b1;
      #1;
      chk("R3 in_ready follows wr_ready", in_ready, wr_ready);
      chk("R4 write valid with sample", wr_valid, 1);
      if (wr_ready) begin
        chk("R4 write data", wr_data, in_data);
        chk("R5 R8 R9 write address", wr_addr, 32'(AW'(m_base[id] + m_wp[id])));
        m_wp[id] = (m_wp[id] + 1) % m_size[id];
        got++;
      end else begin
        chk("R10 no accept while stalled", in_ready, 0);
      end
      cyc++;
      @(negedge clk);
    end
    // pointer write, first stalled then accepted, with input still offered
    in_valid = 1'b1; wr_ready = 1'b0;
    #1;
    chk("R6 input refused after last sample", in_ready, 0);
    chk("R6 pointer write valid", wr_valid, 1);
    chk("R6 pointer address", wr_addr, 32'(m_paddr[id]));
    chk("R6 pointer data", wr_data, 32'(m_wp[id]));
    @(negedge clk);
    wr_ready = 1'b1;
    #1;
    chk("R10 pointer address held", wr_addr, 32'(m_paddr[id]));
    chk("R10 pointer data held", wr_data, 32'(m_wp[id]));
    chk("R7 no early done", drain_done, 0);
    @(negedge clk);
    #1;
    chk("R7 drain_done pulse", drain_done, 1);
    chk("R7 busy low with done", busy, 0);
    chk("R2 idle no ready", in_ready, 0);
    chk("R2 idle no write", wr_valid, 0);
    @(negedge clk);
    #1;
    chk("R7 drain_done single cycle", drain_done, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 wr_valid in reset", wr_valid, 0);
    chk("R1 drain_done in reset", drain_done, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; wr_ready = 1'b1;
    #1;
    chk("R1 busy after reset", busy, 0);
    chk("R1 R2 in_ready idle", in_ready, 0);
    chk("R1 R2 wr_valid idle", wr_valid, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    cfg(0, 'h100, 8, 4, 'h2000);
    cfg(1, 'h300, 3, 5, 'h2004);
    cfg(2, 'h500, 4, 1, 'h2008);
    run_block(0, 1'b0, 1);   // R4 back-to-back samples
    run_block(1, 1'b1, 2);   // R5 wrap under stalls
    run_block(0, 1'b0, 3);   // R8 continues at offset 4, wraps to 0
    run_block(1, 1'b1, 4);   // R8 continues at offset 2
    cfg(1, 'h380, 3, 2, 'h200C);
    run_block(1, 1'b0, 5);   // R9 restarts at offset 0 with new base
    run_block(2, 1'b1, 6);   // block of one sample
    run_block(2, 1'b0, 7);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule